// File: doc/BRIEF.md
# Bus-to-Parallel-Port Data Bridge

This block is a target on a request/response shared-memory interconnect that exposes two 32-bit parallel data ports to an external sampled-data domain. A write command places its data into a held output register that continuously drives the outgoing port. A read command samples the incoming port at the moment the command is taken and returns that sample in the response packet. There is no register map: every accepted command touches the same pair of data registers, and any address decoding happens upstream.

The block runs one command at a time. It takes a command in its idle state and then presents a single-cell response until the initiator acknowledges it. The end-of-packet marker of the command is kept in a register so that the response cell repeats it. Every output is taken from registers. The block runs on one clock and has an active-low reset.

Top module: `vci_gpio_bridge`

## Requirements
- R1: After reset, cmd_ack is 1, rsp_valid is 0 and ext_out is 0.
- R2: cmd_ack is 1 only while no response is pending. A command offered while a response is pending has no effect on ext_out or on the response.
- R3: A write command (cmd_code 2'b10) that is accepted (cmd_valid and cmd_ack both 1 at a rising edge) makes ext_out equal cmd_wdata from the next cycle on.
- R4: An accepted read makes the response carry the value ext_in had at the accepting edge. Later changes of ext_in leave that response unchanged.
- R5: rsp_valid stays 1, with rsp_data and rsp_eop stable, until an edge at which rsp_ack is 1.
- R6: rsp_eop equals the cmd_eop value of the accepted command.
- R7: The response to a write carries rsp_data equal to 0.
- R8: A read leaves ext_out unchanged.
- R9: Only cmd_code 2'b10 is a write. Codes 2'b00, 2'b01 and 2'b11 are all served as a read.
- R10: rsp_err is 0 in every response.
- R11: rsp_valid rises in the cycle after acceptance. In the cycle after the rsp_ack handshake, rsp_valid is 0 and cmd_ack is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ack | output | 1 | Command can be taken this cycle |
| cmd_code | input | 2 | Command code, 2'b10 write, any other value read |
| cmd_wdata | input | 32 | Write data |
| cmd_eop | input | 1 | End-of-packet marker of the command |
| rsp_valid | output | 1 | Response valid |
| rsp_ack | input | 1 | Initiator accepts the response |
| rsp_data | output | 32 | Read sample, or 0 for a write |
| rsp_eop | output | 1 | End-of-packet marker of the response |
| rsp_err | output | 1 | Error flag, always 0 |
| ext_in | input | 32 | Data arriving from the external domain |
| ext_out | output | 32 | Held data driven to the external domain |

## Verification
The bench drives every command code with both end-of-packet values. Walking-one and walking-zero patterns go on both the write data and the input port, so that a stuck or swapped data bit, or a wrong read/write decode, shows up as a wrong response value or a wrong output value. After each acceptance the input port is inverted, which separates a true capture from a transparent path. Each response is held for zero to three extra cycles while a conflicting write is offered, so that a response dropped early, a changing response and a command taken while busy all give different results.

// File: rtl/vgb_pkg.sv
package vgb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_RSP = 2'd1,
    ST_WR_RSP = 2'd2
  } vgb_state_e;

  localparam logic [1:0] CODE_READ  = 2'b01;
  localparam logic [1:0] CODE_WRITE = 2'b10;

  // Only the write code writes; everything else is served as a read.
  function automatic logic code_is_write(input logic [1:0] code);
    return code == CODE_WRITE;
  endfunction

  function automatic logic state_has_rsp(input vgb_state_e st);
    return st != ST_IDLE;
  endfunction

endpackage

// File: rtl/vgb_ctrl.sv
module vgb_ctrl
  import vgb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  input  logic       cmd_eop,
  input  logic       rsp_ack,
  output logic       cmd_ack,
  output logic       rsp_valid,
  output logic       rsp_eop,
  output logic       rsp_is_read,
  output logic       wr_accept,
  output logic       rd_accept
);

  vgb_state_e state_q, state_d;
  logic       eop_q;
  logic       accept;

  assign cmd_ack     = (state_q == ST_IDLE);
  assign accept      = cmd_valid & cmd_ack;
  assign wr_accept   = accept & code_is_write(cmd_code);
  assign rd_accept   = accept & ~code_is_write(cmd_code);
  assign rsp_valid   = state_has_rsp(state_q);
  assign rsp_is_read = (state_q == ST_RD_RSP);
  assign rsp_eop     = eop_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (wr_accept)      state_d = ST_WR_RSP;
        else if (rd_accept) state_d = ST_RD_RSP;
      end
      ST_RD_RSP, ST_WR_RSP: begin
        if (rsp_ack) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      eop_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) eop_q <= cmd_eop;
    end
  end

  p_rsp_follows_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept || rd_accept) |=> rsp_valid);

  p_rsp_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_eop)));

  p_idle_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ack) |=> (cmd_ack && !rsp_valid));

  p_eop_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept || rd_accept) |=> (rsp_eop == $past(cmd_eop)));

  p_no_take_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(wr_accept || rd_accept));

endmodule

// File: rtl/vgb_datapath.sv
module vgb_datapath #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_accept,
  input  logic              rd_accept,
  input  logic              rsp_is_read,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] ext_out,
  output logic [DATA_W-1:0] rsp_data
);

  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [DATA_W-1:0] wr_q;
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= ZERO;
      rd_q <= ZERO;
    end else begin
      if (wr_accept) wr_q <= cmd_wdata;
      if (rd_accept) rd_q <= ext_in;
    end
  end

  assign ext_out  = wr_q;
  assign rsp_data = rsp_is_read ? rd_q : ZERO;

  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (ext_out == $past(cmd_wdata)));

  p_read_keeps_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> $stable(ext_out));

  p_read_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> (rsp_data == $past(ext_in)));

  p_write_rsp_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (rsp_data == ZERO));

endmodule

// File: rtl/vci_gpio_bridge.sv
module vci_gpio_bridge #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ack,
  input  logic [1:0]        cmd_code,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_eop,
  output logic              rsp_valid,
  input  logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_eop,
  output logic              rsp_err,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] ext_out
);

  logic wr_accept;
  logic rd_accept;
  logic rsp_is_read;

  vgb_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_eop     (cmd_eop),
    .rsp_ack     (rsp_ack),
    .cmd_ack     (cmd_ack),
    .rsp_valid   (rsp_valid),
    .rsp_eop     (rsp_eop),
    .rsp_is_read (rsp_is_read),
    .wr_accept   (wr_accept),
    .rd_accept   (rd_accept)
  );

  vgb_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_accept   (wr_accept),
    .rd_accept   (rd_accept),
    .rsp_is_read (rsp_is_read),
    .cmd_wdata   (cmd_wdata),
    .ext_in      (ext_in),
    .ext_out     (ext_out),
    .rsp_data    (rsp_data)
  );

  assign rsp_err = 1'b0;

  p_data_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ack) |=> $stable(rsp_data));

endmodule

// File: tb/vci_gpio_bridge_test.sv
module vci_gpio_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ack;
  logic [1:0]  cmd_code = 2'b00;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_eop = 1'b0;
  logic        rsp_valid;
  logic        rsp_ack = 1'b0;
  logic [31:0] rsp_data;
  logic        rsp_eop;
  logic        rsp_err;
  logic [31:0] ext_in = '0;
  logic [31:0] ext_out;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_out = '0;

  always #5 clk = ~clk;

  vci_gpio_bridge uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ack(cmd_ack),
    .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .cmd_eop(cmd_eop),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
    .rsp_eop(rsp_eop), .rsp_err(rsp_err), .ext_in(ext_in), .ext_out(ext_out)
  );

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // One full transaction; inputs change at falling edges, outputs sampled there.
  task automatic txn(input logic [1:0] code, input logic [31:0] wd,
                     input logic [31:0] smp, input logic eop, input int hold);
    logic        is_wr;
    logic [31:0] exp_rsp;
    is_wr   = (code == 2'b10);
    exp_rsp = is_wr ? 32'h0 : smp;
    @(negedge clk);
    check(cmd_ack === 1'b1, "R2 idle ack", {31'b0, cmd_ack}, 32'd1);
    cmd_valid = 1'b1; cmd_code = code; cmd_wdata = wd; cmd_eop = eop; ext_in = smp;
    @(negedge clk);
    if (is_wr) exp_out = wd;
    // R4: disturb the input after the capture edge
    ext_in = ~smp;
    // R2: keep offering a conflicting write while busy
    cmd_code = 2'b10; cmd_wdata = ~wd ^ 32'h5A5A_A5A5; cmd_eop = ~eop;
    rsp_ack = (hold == 0);
    check(rsp_valid === 1'b1, "R11 rsp after accept", {31'b0, rsp_valid}, 32'd1);
    check(cmd_ack === 1'b0, "R2 busy ack", {31'b0, cmd_ack}, 32'd0);
    check(rsp_eop === eop, "R6 eop", {31'b0, rsp_eop}, {31'b0, eop});
    check(rsp_err === 1'b0, "R10 err", {31'b0, rsp_err}, 32'd0);
    check(rsp_data === exp_rsp, is_wr ? "R7 write rsp zero" : "R4 R9 read sample",
          rsp_data, exp_rsp);
    check(ext_out === exp_out, is_wr ? "R3 write out" : "R8 read keeps out",
          ext_out, exp_out);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      rsp_ack = (k == hold - 1);
      check(rsp_valid === 1'b1, "R5 held", {31'b0, rsp_valid}, 32'd1);
      check(rsp_data === exp_rsp, "R5 data stable", rsp_data, exp_rsp);
      check(rsp_eop === eop, "R5 eop stable", {31'b0, rsp_eop}, {31'b0, eop});
    end
    @(negedge clk);
    cmd_valid = 1'b0; rsp_ack = 1'b0;
    check(rsp_valid === 1'b0, "R11 drop after ack", {31'b0, rsp_valid}, 32'd0);
    check(cmd_ack === 1'b1, "R11 idle after ack", {31'b0, cmd_ack}, 32'd1);
    check(ext_out === exp_out, "R2 busy write ignored", ext_out, exp_out);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cmd_ack === 1'b1, "R1 ack", {31'b0, cmd_ack}, 32'd1);
    check(rsp_valid === 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check(ext_out === 32'h0, "R1 ext_out", ext_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ext_out === 32'h0, "R1 ext_out after release", ext_out, 32'h0);
    // R9 sweep of codes and eop values with walking patterns
    for (int i = 0; i < 32; i++) begin
      for (int c = 0; c < 4; c++) begin
        txn(2'(c), 32'h1 << i, ~(32'h1 << ((i + c) % 32)), 1'((i + c) % 2), (i + c) % 4);
      end
    end
    for (int i = 0; i < 32; i++) begin
      txn(2'b10, ~(32'h1 << i), 32'h1 << i, 1'(i % 2), i % 3);
      txn(2'b01, 32'hFFFF_FFFF, ~(32'h1 << i), 1'((i + 1) % 2), 0);
    end
    finish_run();
  end

endmodule